// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Emulator

This block is a clocked, synthesizable stand-in for an asynchronous word-wide static memory slave with separate upper and lower byte lanes. Five active-low control pins (chip select, write strobe, output enable, upper byte select, lower byte select) are sampled by a fast system clock. A truth table decoded from those pins decides, for each byte lane on its own, whether it is read, written or left undriven. Each lane has its own input data, output data and output drive flag, so a testbench or a pad wrapper can see exactly when the emulated part would drive its pins.

A write is open while chip select, write strobe and a lane's byte select are all low. The lane's stored byte changes only when that overlap closes, whichever of the three pins rises first. The value stored is the address and data captured on the last sampled cycle that the overlap was still open. The storage depth is a parameter. Only the low address bits that index the array are decoded, and a synchronous reset stops the outputs from driving while leaving the stored data untouched, much as a nonvolatile part keeps its data through a power cycle.

Top module: `bytelane_mem_emu`

## Requirements
- R1: While chip select is high, neither lane drives, whatever the other pins do. Output state follows the pins two clock edges after they change.
- R2: With chip select low, write strobe high and output enable low, a lane drives only if its byte select is low, and it returns the byte stored at the address. The lower lane is data bits 7:0 and the upper lane is bits 15:8. Lower only, upper only and both are each supported.
- R3: With chip select low and both byte selects high, or with output enable and write strobe both high, neither lane drives.
- R4: While chip select and write strobe are both low, neither lane drives, even when output enable is low.
- R5: A lane's write commits when its overlap of chip select low, write strobe low and byte select low ends. It commits the same way whether write strobe, chip select or the byte select is the pin that rises.
- R6: During a write, a lane whose byte select is high keeps its stored byte unchanged.
- R7: Synchronous reset clears both drive flags. Stored contents survive a reset.
- R8: Only the low DEPTH_BITS address bits select a word. Addresses that differ only in higher bits reach the same word.
- R9: The committed byte is the data sampled on the last cycle the overlap was open. Data that changes on the same cycle the overlap ends is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte select, active low |
| lb_n | input | 1 | Lower byte select, active low |
| addr | input | ADDR_W (18) | Word address |
| lo_din | input | 8 | Lower lane write data |
| hi_din | input | 8 | Upper lane write data |
| lo_dout | output | 8 | Lower lane read data |
| hi_dout | output | 8 | Upper lane read data |
| lo_drive | output | 1 | Lower lane output drive enable |
| hi_drive | output | 1 | Upper lane output drive enable |

## Verification
The hardest case to reach from the ports is the commit point itself. Only the closing of the overlap stores data, so the stimulus has to end writes in three different ways: by raising write strobe, by raising chip select, and by raising a byte select. Each way is then read back. One write changes its data on the very cycle the strobe rises, which shows that the earlier sampled value is the one kept. A write held with output enable low is checked partway through to confirm that no lane drives during it.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_LANES = 2;
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;

    // Sampled control pins, all active low
    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic ub_n;
        logic lb_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                    ub_n: 1'b1, lb_n: 1'b1};

    // Per-lane requests: index 0 is the lower lane, 1 the upper
    typedef struct packed {
        logic [N_LANES-1:0] wr;
        logic [N_LANES-1:0] rd;
    } lane_req_t;

    function automatic lane_req_t decode_pins(pins_t p);
        lane_req_t r;
        logic [N_LANES-1:0] sel;
        sel = {~p.ub_n, ~p.lb_n};
        for (int i = 0; i < N_LANES; i++) begin
            r.wr[i] = ~p.cs_n & ~p.we_n & sel[i];
            r.rd[i] = ~p.cs_n &  p.we_n & ~p.oe_n & sel[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/bytelane_ctrl_sync.sv
module bytelane_ctrl_sync
    import bytelane_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  pins_t             pins,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [DATA_W-1:0] din,
    output pins_t             pins_q,
    output lane_req_t         req,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] din_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= PINS_IDLE;
        end else begin
            pins_q <= pins;
        end
        idx_q <= idx_in;
        din_q <= din;
    end

    always_comb begin
        req = decode_pins(pins_q);
    end

endmodule

// File: rtl/bytelane_lane.sv
module bytelane_lane #(
    parameter int IDX_W  = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_act,
    input  logic              rd_act,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              drive
);

    localparam int DEPTH = 1 << IDX_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              act_q;
    logic [IDX_W-1:0]  hold_idx;
    logic [BYTE_W-1:0] hold_data;
    logic              commit;

    // Overlap just closed: store what was held on its last open cycle
    assign commit = act_q & ~wr_act & ~rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
        end else begin
            act_q <= wr_act;
        end
        if (wr_act) begin
            hold_idx  <= idx;
            hold_data <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            mem[hold_idx] <= hold_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive <= 1'b0;
        end else begin
            drive <= rd_act;
        end
        if (rd_act) begin
            dout <= mem[idx];
        end
    end

    // R7: reset leaves the lane undriven
    a_r7_reset_no_drive: assert property (@(posedge clk)
        rst |=> !drive);

    // R4: an open write never turns into lane drive
    a_r4_no_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        wr_act |=> !drive);

    // R5: closing the overlap lands the held byte in the array
    a_r5_commit_stores: assert property (@(posedge clk) disable iff (rst)
        commit |=> mem[$past(hold_idx)] == $past(hold_data));

endmodule

// File: rtl/bytelane_mem_emu.sv
module bytelane_mem_emu
    import bytelane_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DEPTH_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        lo_din,
    input  logic [7:0]        hi_din,
    output logic [7:0]        lo_dout,
    output logic [7:0]        hi_dout,
    output logic              lo_drive,
    output logic              hi_drive
);

    localparam int DATA_W = N_LANES * BYTE_W;

    pins_t                  pins_now;
    pins_t                  pins_q;
    lane_req_t              req;
    logic [DEPTH_BITS-1:0]  idx_q;
    logic [DATA_W-1:0]      din_q;
    logic [BYTE_W-1:0]      dout_v [N_LANES];
    logic [N_LANES-1:0]     drive_v;

    assign pins_now = '{cs_n: cs_n, we_n: we_n, oe_n: oe_n, ub_n: ub_n, lb_n: lb_n};

    bytelane_ctrl_sync #(
        .IDX_W  (DEPTH_BITS),
        .DATA_W (DATA_W)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins   (pins_now),
        .idx_in (addr[DEPTH_BITS-1:0]),
        .din    ({hi_din, lo_din}),
        .pins_q (pins_q),
        .req    (req),
        .idx_q  (idx_q),
        .din_q  (din_q)
    );

    generate
        if (DEPTH_BITS < ADDR_W) begin : g_alias
            logic hi_addr_unused;
            assign hi_addr_unused = ^addr[ADDR_W-1:DEPTH_BITS];
        end
        for (genvar i = 0; i < N_LANES; i++) begin : g_lane
            bytelane_lane #(
                .IDX_W  (DEPTH_BITS),
                .BYTE_W (BYTE_W)
            ) u_lane (
                .clk    (clk),
                .rst    (rst),
                .wr_act (req.wr[i]),
                .rd_act (req.rd[i]),
                .idx    (idx_q),
                .din    (din_q[i*BYTE_W +: BYTE_W]),
                .dout   (dout_v[i]),
                .drive  (drive_v[i])
            );
        end
    endgenerate

    assign lo_dout  = dout_v[LANE_LO];
    assign hi_dout  = dout_v[LANE_HI];
    assign lo_drive = drive_v[LANE_LO];
    assign hi_drive = drive_v[LANE_HI];

    // R1: a deselected cycle is followed by no drive on either lane
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        pins_q.cs_n |=> (!lo_drive && !hi_drive));

endmodule

// File: tb/bytelane_mem_emu_tb.sv
module bytelane_mem_emu_tb;

    localparam int AW = 18;
    localparam int DB = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    lo_din = '0, hi_din = '0;
    logic [7:0]    lo_dout, hi_dout;
    logic          lo_drive, hi_drive;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] exp_lo [1<<DB];
    logic [7:0] exp_hi [1<<DB];

    always #2.5 clk = ~clk;

    bytelane_mem_emu #(.ADDR_W(AW), .DEPTH_BITS(DB)) u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .lo_din(lo_din), .hi_din(hi_din),
        .lo_dout(lo_dout), .hi_dout(hi_dout), .lo_drive(lo_drive), .hi_drive(hi_drive)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1; we_n = 1; oe_n = 1; ub_n = 1; lb_n = 1;
    endtask

    // end_by: 0 write strobe, 1 chip select, 2 byte selects
    task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic lbn, logic ubn,
                            int end_by, logic oen);
        @(negedge clk);
        addr = a; lo_din = d[7:0]; hi_din = d[15:8];
        cs_n = 0; we_n = 0; oe_n = oen; lb_n = lbn; ub_n = ubn;
        repeat (3) @(negedge clk);
        if (!oen) chk("R4 drive during write", {14'b0, hi_drive, lo_drive}, 16'h0);
        case (end_by)
            0: we_n = 1;
            1: cs_n = 1;
            default: begin lb_n = 1; ub_n = 1; end
        endcase
        repeat (3) @(negedge clk);
        idle();
        if (!lbn) exp_lo[a[DB-1:0]] = d[7:0];
        if (!ubn) exp_hi[a[DB-1:0]] = d[15:8];
    endtask

    task automatic do_read(string req, logic [AW-1:0] a, logic lbn, logic ubn);
        @(negedge clk);
        addr = a; cs_n = 0; we_n = 1; oe_n = 0; lb_n = lbn; ub_n = ubn;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(req, {14'b0, hi_drive, lo_drive}, {14'b0, !ubn, !lbn});
        if (!lbn) chk(req, {8'h0, lo_dout}, {8'h0, exp_lo[a[DB-1:0]]});
        if (!ubn) chk(req, {8'h0, hi_dout}, {8'h0, exp_hi[a[DB-1:0]]});
        idle();
    endtask

    task automatic pins_quiet(string req, logic c, logic w, logic o, logic l, logic u);
        @(negedge clk);
        addr = 3; cs_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(req, {14'b0, hi_drive, lo_drive}, 16'h0);
        idle();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R7 drive after reset", {14'b0, hi_drive, lo_drive}, 16'h0);
    endtask

    task automatic t_word_and_lanes();
        do_write(3, 16'hA55A, 0, 0, 0, 1);
        do_read("R2 word read", 3, 0, 0);
        do_write(3, 16'h1234, 0, 1, 0, 1);
        do_read("R6 upper kept", 3, 1, 0);
        do_read("R2 lower only", 3, 0, 1);
    endtask

    task automatic t_end_variants();
        do_write(7, 16'hBEEF, 0, 0, 1, 1);
        do_read("R5 ended by chip select", 7, 0, 0);
        do_write(7, 16'h0011, 0, 1, 2, 1);
        do_read("R5 ended by byte select", 7, 0, 0);
        do_write(9, 16'hC3C3, 1, 0, 0, 0);
        do_read("R4 write with output enable low", 9, 1, 0);
        do_read("R6 lower untouched", 9, 0, 1);
    endtask

    task automatic t_quiet();
        pins_quiet("R1 deselected", 1, 1, 0, 0, 0);
        pins_quiet("R3 no byte select", 0, 1, 0, 1, 1);
        pins_quiet("R3 output enable high", 0, 1, 1, 0, 0);
    endtask

    task automatic t_retain();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        chk("R7 drive in reset", {14'b0, hi_drive, lo_drive}, 16'h0);
        rst = 0;
        do_read("R7 contents kept", 3, 0, 0);
    endtask

    task automatic t_alias();
        do_write(AW'(18'h2_0405), 16'h6789, 0, 0, 0, 1);
        do_read("R8 alias read", 5, 0, 0);
    endtask

    task automatic t_late_data();
        @(negedge clk);
        addr = 12; lo_din = 8'h5A; hi_din = 8'hA5;
        cs_n = 0; we_n = 0; oe_n = 1; lb_n = 0; ub_n = 0;
        repeat (3) @(negedge clk);
        we_n = 1; lo_din = 8'hFF; hi_din = 8'hEE;
        repeat (3) @(negedge clk);
        idle();
        exp_lo[12] = 8'h5A; exp_hi[12] = 8'hA5;
        do_read("R9 late data dropped", 12, 0, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_word_and_lanes();
                t_end_variants();
                t_quiet();
                t_retain();
                t_alias();
                t_late_data();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule